// File: doc/BRIEF.md
# Tagged Sample Smoothing Filter

This block smooths a stream of converter samples with a first-order recursive low-pass filter. Each incoming sample carries a valid strobe, a 12-bit value, a 4-bit channel index and a 1-bit unit tag. The filter is bound by configuration to one unit and either to one channel or to every valid channel of that unit. Only samples whose tags match move the filter state. Each sample it takes produces one filtered result, with its own valid strobe, on the following cycle.

The smoothing weight is 1/k, where k is a power of two picked by a 3-bit code. The update is therefore a subtract, an arithmetic shift and an add, with no multiplier. The state carries six fraction bits below the 12-bit sample. The step toward the sample is never smaller than one fractional LSB, so a constant input is reached exactly. When the filter is disabled, matching samples are forwarded unchanged. The first matching sample after reset or after re-enabling seeds the state directly.

Top module: `smp_iir_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, and the filter is unseeded.
- R2: A sample is accepted only when `in_valid` is 1, `in_unit` equals `cfg_unit`, and either `cfg_all_chan` is 1 or `in_chan` equals `cfg_chan`. Any other sample causes no output strobe and leaves the filter state unchanged.
- R3: A sample with `in_chan` of 10 or more (channels 0 to 9 are valid) is never accepted, even when `cfg_all_chan` is 1.
- R4: `out_valid` is 1 in exactly the cycle after each accepted sample. `out_data` holds its last value in every other cycle.
- R5: With `cfg_en` at 1, the first accepted sample after reset, or after `cfg_en` was 0, loads the state with sample·64 and outputs the sample itself.
- R6: Each later accepted sample with `cfg_en` at 1 adds step = (sample·64 − state) >> s to the 18-bit state, where >> is an arithmetic (floor) shift. A step of 0 with a nonzero difference becomes +1 or −1, following the sign of the difference. `out_data` is state >> 6.
- R7: The shift s is set by `cfg_coef`: 0→1 (k=2), 1→2 (k=4), 2→3 (k=8), 3→4 (k=16), 4→6 (k=64). Codes 5 to 7 also give 6.
- R8: When the same sample value is fed repeatedly, `out_data` reaches exactly that value and stays there, with no overshoot, for every k.
- R9: While `cfg_en` is 0, every accepted sample appears unchanged on `out_data` one cycle later, the state is not updated, and the filter is left unseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | 1 = filter, 0 = forward samples unchanged |
| cfg_coef | input | 3 | Smoothing code selecting k |
| cfg_unit | input | 1 | Unit tag this filter listens to |
| cfg_all_chan | input | 1 | 1 = accept every valid channel of the unit |
| cfg_chan | input | 4 | Channel listened to when `cfg_all_chan` is 0 |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 12 | Sample value |
| in_chan | input | 4 | Sample channel tag |
| in_unit | input | 1 | Sample unit tag |
| out_valid | output | 1 | Filtered result strobe |
| out_data | output | 12 | Filtered result |

## Verification
A wrong fraction bit or a wrong seed flag only shows up at the next accepted sample. Every later output then differs from the arithmetic reference by a drifting amount, so the bench compares both outputs against an integer model on every clock. Tag-gating errors show as a stray or missing strobe in the very next cycle. Weak rounding shows up only at the end of a long constant run, where the output stops one count short of the input. For that reason each coefficient is driven to convergence from both directions.

// File: rtl/siir_pkg.sv
package siir_pkg;
    // Smoothing codes; the first LIN_CODES map to shift = code + 1.
    typedef enum logic [2:0] {
        COEF_K2  = 3'd0,
        COEF_K4  = 3'd1,
        COEF_K8  = 3'd2,
        COEF_K16 = 3'd3,
        COEF_K64 = 3'd4
    } coef_sel_e;

    localparam int unsigned LIN_CODES = 4;
    localparam int unsigned TOP_SHIFT = 6;
endpackage

// File: rtl/siir_tag_gate.sv
module siir_tag_gate #(
    parameter int unsigned CHAN_W   = 4,
    parameter int unsigned NUM_CHAN = 10
) (
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_unit,
    input  logic              cfg_unit,
    input  logic              cfg_all_chan,
    input  logic [CHAN_W-1:0] cfg_chan,
    output logic              accept
);
    localparam logic [CHAN_W:0] CHAN_LIMIT = (CHAN_W+1)'(NUM_CHAN);

    logic chan_legal;
    logic chan_hit;
    logic unit_hit;

    always_comb begin
        chan_legal = ({1'b0, in_chan} < CHAN_LIMIT);
        chan_hit   = cfg_all_chan || (in_chan == cfg_chan);
        unit_hit   = (in_unit == cfg_unit);
        accept     = in_valid && unit_hit && chan_legal && chan_hit;
    end
endmodule

// File: rtl/siir_shift_sel.sv
module siir_shift_sel #(
    parameter int unsigned MAX_SHIFT = siir_pkg::TOP_SHIFT,
    parameter int unsigned CODE_W    = 3,
    localparam int unsigned SH_W     = $clog2(MAX_SHIFT + 1),
    localparam int unsigned CODES    = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [SH_W-1:0]   shift
);
    logic [SH_W-1:0] lut [CODES];

    for (genvar i = 0; i < CODES; i++) begin : g_lut
        localparam int unsigned SH = (i < siir_pkg::LIN_CODES) ? i + 1 : MAX_SHIFT;
        assign lut[i] = SH_W'(SH);
    end

    always_comb shift = lut[code];
endmodule

// File: rtl/siir_core.sv
module siir_core #(
    parameter int unsigned DATA_W    = 12,
    parameter int unsigned FRAC_W    = siir_pkg::TOP_SHIFT,
    localparam int unsigned ST_W     = DATA_W + FRAC_W,
    localparam int unsigned SH_W     = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              enable,
    input  logic [SH_W-1:0]   shift,
    input  logic [DATA_W-1:0] sample,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    typedef struct packed {
        logic              primed;
        logic [ST_W-1:0]   st;
        logic              vld;
        logic [DATA_W-1:0] dat;
    } core_t;

    core_t cur_q, nxt_d;

    logic signed [ST_W:0] diff;
    logic signed [ST_W:0] step;
    logic signed [ST_W:0] sum;
    logic [ST_W-1:0]      upd;
    logic [ST_W-1:0]      seed;

    always_comb begin
        seed = {sample, {FRAC_W{1'b0}}};
        diff = $signed({1'b0, seed}) - $signed({1'b0, cur_q.st});
        step = diff >>> shift;
        if (step == '0 && diff != '0) begin
            step = diff[ST_W] ? -(ST_W+1)'(1) : (ST_W+1)'(1);
        end
        sum = $signed({1'b0, cur_q.st}) + step;
        upd = sum[ST_W-1:0];

        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (accept) begin
            nxt_d.vld = 1'b1;
            if (!enable) begin
                nxt_d.dat = sample;
            end else if (!cur_q.primed) begin
                nxt_d.st     = seed;
                nxt_d.dat    = sample;
                nxt_d.primed = 1'b1;
            end else begin
                nxt_d.st  = upd;
                nxt_d.dat = upd[ST_W-1:FRAC_W];
            end
        end
        if (!enable) nxt_d.primed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign res_valid = cur_q.vld;
    assign res_data  = cur_q.dat;

    // R5
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && enable && !cur_q.primed) |=> (cur_q.st == {$past(sample), {FRAC_W{1'b0}}}));

    // R8
    no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && enable && cur_q.primed && (seed >= cur_q.st)) |=>
            (cur_q.st >= $past(cur_q.st) && cur_q.st <= {$past(sample), {FRAC_W{1'b0}}}));

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !enable) |=> (res_data == $past(sample) && !cur_q.primed));
endmodule

// File: rtl/smp_iir_filter.sv
module smp_iir_filter #(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned CHAN_W   = 4,
    parameter int unsigned NUM_CHAN = 10,
    parameter int unsigned FRAC_W   = siir_pkg::TOP_SHIFT,
    localparam int unsigned SH_W    = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [2:0]        cfg_coef,
    input  logic              cfg_unit,
    input  logic              cfg_all_chan,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_unit,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic            accept;
    logic [SH_W-1:0] shift;

    siir_tag_gate #(.CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)) u_gate (
        .in_valid     (in_valid),
        .in_chan      (in_chan),
        .in_unit      (in_unit),
        .cfg_unit     (cfg_unit),
        .cfg_all_chan (cfg_all_chan),
        .cfg_chan     (cfg_chan),
        .accept       (accept)
    );

    siir_shift_sel #(.MAX_SHIFT(FRAC_W), .CODE_W(3)) u_shift (
        .code  (cfg_coef),
        .shift (shift)
    );

    siir_core #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .enable    (cfg_en),
        .shift     (shift),
        .sample    (in_data),
        .res_valid (out_valid),
        .res_data  (out_data)
    );

    // R4
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R4
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && $stable(out_data)));

    // R3
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, in_chan} >= (CHAN_W+1)'(NUM_CHAN)) |-> !accept);
endmodule

// File: tb/test_smp_iir_filter.sv
module test_smp_iir_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_unit = 1'b0, cfg_all_chan = 1'b0;
    logic [2:0] cfg_coef = 3'd0;
    logic [3:0] cfg_chan = 4'd0;
    logic in_valid = 1'b0, in_unit = 1'b0;
    logic [11:0] in_data = 12'd0;
    logic [3:0] in_chan = 4'd0;
    logic out_valid;
    logic [11:0] out_data;

    int tests = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    bit m_primed = 0;
    int m_state = 0;
    bit m_ov = 0;
    int m_od = 0;
    int lfsr = 32'h1ACE;

    always #10 clk = ~clk;

    smp_iir_filter i_smp_iir_filter (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_coef(cfg_coef),
        .cfg_unit(cfg_unit), .cfg_all_chan(cfg_all_chan), .cfg_chan(cfg_chan),
        .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan), .in_unit(in_unit),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int shift_for(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_primed = 0; m_state = 0; m_ov = 0; m_od = 0;
        end else begin
            bit take;
            take = in_valid && (in_unit == cfg_unit) && (in_chan < 10)
                   && (cfg_all_chan || in_chan == cfg_chan);
            m_ov = take;
            if (take) begin
                if (!cfg_en) begin
                    m_od = in_data;
                end else if (!m_primed) begin
                    m_state = in_data * 64; m_od = in_data; m_primed = 1;
                end else begin
                    int d, dv, st;
                    d  = in_data * 64 - m_state;
                    dv = 1 << shift_for(cfg_coef);
                    if (d > 0) begin
                        st = d / dv;
                        if (st == 0) st = 1;
                    end else if (d < 0) begin
                        st = -((-d + dv - 1) / dv);
                    end else st = 0;
                    m_state = m_state + st;
                    m_od = m_state / 64;
                end
            end
            if (!cfg_en) m_primed = 0;
        end
    end

    task automatic check(string req, string what, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // one clock: compare at negedge, then drive new inputs
    task automatic cyc(bit v, int d, int ch, bit u);
        @(negedge clk);
        check(tag, "out_valid", int'(out_valid), int'(m_ov));
        check(tag, "out_data", int'(out_data), m_od);
        in_valid = v; in_data = 12'(d); in_chan = 4'(ch); in_unit = u;
    endtask

    function automatic int nextrnd();
        lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) ? 32'h04C11DB7 : 0);
        return lfsr & 32'h7FFF_FFFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "out_data", int'(out_data), 0);
        rst_n = 1'b1;

        // R5 seed then R6 updates, k=8 on unit 0 channel 3
        cfg_en = 1; cfg_coef = 3'd2; cfg_chan = 4'd3;
        tag = "R5";
        cyc(1, 1000, 3, 0);
        cyc(0, 0, 0, 0);
        @(negedge clk);
        check("R5", "seed out_data", int'(out_data), 1000);
        tag = "R6";
        cyc(1, 2000, 3, 0);
        cyc(1, 2000, 3, 0);
        cyc(1, 123, 3, 0);
        cyc(0, 0, 0, 0);

        // R2 non-matching samples: wrong unit, wrong channel
        tag = "R2";
        for (int i = 0; i < 40; i++) begin
            int r;
            r = nextrnd();
            cyc(1, r % 4096, (r >> 12) % 10, (r >> 20) & 1);
        end
        cyc(1, 4095, 4, 0);
        cyc(1, 4095, 3, 1);
        cyc(0, 0, 0, 0);

        // R3 all-channel mode with out-of-range indices
        tag = "R3";
        cfg_all_chan = 1; cfg_unit = 1;
        for (int ch = 0; ch < 16; ch++) cyc(1, 300 + ch * 50, ch, 1);
        cyc(0, 0, 0, 0);
        cyc(1, 3000, 12, 1);
        cyc(0, 0, 0, 0);
        @(negedge clk);
        check("R3", "no strobe for channel 12", int'(out_valid), 0);

        // R4 gaps and back-to-back mix
        tag = "R4";
        for (int i = 0; i < 60; i++) begin
            int r;
            r = nextrnd();
            cyc((r & 3) != 0, (r >> 4) % 4096, (r >> 16) % 16, 1);
        end

        // R7 every code with varied data
        for (int c = 0; c < 8; c++) begin
            tag = "R7";
            cfg_coef = 3'(c);
            cyc(1, 0, 0, 1);
            cyc(1, 4000, 0, 1);
            cyc(1, 4000, 0, 1);
            cyc(1, 17, 5, 1);
            cyc(0, 0, 0, 1);
        end

        // R8 convergence from both sides at every code
        tag = "R8";
        for (int c = 0; c < 5; c++) begin
            cfg_coef = 3'(c);
            for (int i = 0; i < 1200; i++) cyc(1, 4095, 2, 1);
            cyc(0, 0, 0, 1);
            @(negedge clk);
            check("R8", "rise converged", int'(out_data), 4095);
            for (int i = 0; i < 1200; i++) cyc(1, 1, 2, 1);
            cyc(0, 0, 0, 1);
            @(negedge clk);
            check("R8", "fall converged", int'(out_data), 1);
        end

        // R9 bypass, then re-enable reseeds
        tag = "R9";
        cfg_coef = 3'd4;
        cyc(0, 0, 0, 1);
        cfg_en = 0;
        cyc(1, 77, 1, 1);
        cyc(1, 3900, 1, 1);
        cyc(0, 0, 0, 1);
        @(negedge clk);
        check("R9", "bypass value", int'(out_data), 3900);
        cfg_en = 1;
        tag = "R5";
        cyc(1, 2500, 1, 1);
        cyc(0, 0, 0, 1);
        @(negedge clk);
        check("R5", "reseed after enable", int'(out_data), 2500);
        cyc(1, 100, 1, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule